// File: doc/BRIEF.md
# Edge Capture Unit with Two-Entry Stack

This block watches one external input pin and timestamps its transitions. The pin is brought into the clock domain through a two-flop synchronizer. Edges are then found by comparing the synchronized level with its value one cycle earlier. A 2-bit mode picks which transitions count: rising, falling, both or none. An enable input gates capture entirely. On a qualifying edge, the count of one of two free-running 16-bit timers is stored in a two-entry stack. A select bit chooses the timer.

The stored stamps leave through a valid/ready stream. `pop_valid_o` is high whenever the stack holds at least one entry, and `pop_data_o` shows the top (oldest) entry. A pop takes place on a clock edge where both valid and ready are high. It removes the top entry and moves the bottom entry up. Ready may be held high while valid is low; nothing is removed then. There is one exception to the rule that the offered data stays stable until it is taken. If the stack is full and a capture arrives, the oldest entry is deliberately discarded and the offered value changes. That loss is reported in the status field.

A 2-bit occupancy/loss status and a one-cycle capture-event pulse are provided as plain outputs. The pulse is intended for an interrupt controller.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset, `status_o` is 00, `pop_valid_o` and `cap_evt_o` are 0, and `pop_data_o` is 0.
- R2: `edge_mode_i` selects which synchronized transitions capture: 00 none, 01 rising only, 10 falling only, 11 both. With 00, no transition ever stores a value.
- R3: While `cap_en_i` is 0, no transition stores a value and `status_o` does not change because of the pin.
- R4: `tbase_sel_i` = 0 stores `tmr_a_i` and `tbase_sel_i` = 1 stores `tmr_b_i`. The value stored is the one present at the capturing clock edge.
- R5: `status_o` reads 00 when empty, 01 with one entry, 10 with two entries and no loss, and 11 with two entries after at least one capture was lost. `pop_valid_o` is 1 exactly when `status_o` is not 00.
- R6: A pop delivers the top entry on `pop_data_o`, and the former bottom entry becomes the new top.
- R7: A capture while two entries are held discards the top, moves the bottom to the top, writes the new stamp to the bottom and sets `status_o` to 11.
- R8: A pop without a capture in the same cycle, taken from status 11, leaves status 01 and clears the loss indication.
- R9: Ready asserted while the stack is empty removes nothing: status stays 00, valid stays 0 and `pop_data_o` keeps its last value.
- R10: When a pop and a capture land on the same edge, the pop is applied first and then the capture. From one entry the result is one entry holding the new stamp. From two entries (with or without loss) the result is status 10, with the old bottom on top and the new stamp below it.
- R11: `cap_evt_o` is high for exactly one cycle per capture, in the first cycle in which the new status is visible.
- R12: A pin change made before clock edge k is captured at edge k+2 and becomes visible after it. Nothing changes after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Asynchronous external event pin |
| cap_en_i | input | 1 | Capture enable |
| edge_mode_i | input | 2 | Edge select: 00 none, 01 rising, 10 falling, 11 both |
| tbase_sel_i | input | 1 | Time base select: 0 timer A, 1 timer B |
| tmr_a_i | input | 16 | Count of timer A |
| tmr_b_i | input | 16 | Count of timer B |
| pop_valid_o | output | 1 | Stack holds at least one stamp |
| pop_ready_i | input | 1 | Consumer takes the top stamp |
| pop_data_o | output | 16 | Top stamp (last top when empty) |
| status_o | output | 2 | Occupancy and loss status |
| cap_evt_o | output | 1 | One-cycle pulse per capture |

## Verification
The two functions that can fall in the same cycle are a pop and a capture. The bench provokes this by raising ready exactly one cycle before the capturing edge that follows a pin change. It does this with one entry held, with two entries held, and with the loss flag set. A scoreboard queue models pop-then-push order. It judges the data offered before the edge and the status and top value seen afterwards.

// File: rtl/ecap_pkg.sv
package ecap_pkg;
  localparam int unsigned STAMP_W = 16;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  localparam logic [1:0] ST_EMPTY = 2'b00;
  localparam logic [1:0] ST_ONE   = 2'b01;
  localparam logic [1:0] ST_TWO   = 2'b10;
  localparam logic [1:0] ST_LOST  = 2'b11;
endpackage

// File: rtl/ecap_sync.sv
module ecap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/ecap_edge_detect.sv
module ecap_edge_detect
  import ecap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       level_i,
  input  logic       en_i,
  input  logic [1:0] mode_i,
  output logic       hit_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  assign rise = level_i & ~prev_q;
  assign fall = ~level_i & prev_q;

  always_comb begin
    hit_o = 1'b0;
    if (en_i) begin
      unique case (edge_mode_e'(mode_i))
        EDGE_RISE: hit_o = rise;
        EDGE_FALL: hit_o = fall;
        EDGE_BOTH: hit_o = rise | fall;
        default:   hit_o = 1'b0;
      endcase
    end
  end

  AST_NONE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b00) |-> !hit_o); // R2
  AST_HIT_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (level_i != prev_q)); // R2
endmodule

// File: rtl/ecap_stack.sv
module ecap_stack
  import ecap_pkg::*;
#(
  parameter int unsigned W = STAMP_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  output logic [1:0]   status_o
);
  logic [W-1:0] top_q, bot_q, top_d, bot_d;
  logic [1:0]   cnt_q, cnt_d;
  logic         lost_q, lost_d;
  logic         pop_fire;

  assign pop_fire = ready_i && (cnt_q != 2'd0);

  always_comb begin
    top_d  = top_q;
    bot_d  = bot_q;
    cnt_d  = cnt_q;
    lost_d = lost_q;
    unique case (cnt_q)
      2'd0: begin
        if (push_i) begin
          top_d = push_data_i;
          cnt_d = 2'd1;
        end
      end
      2'd1: begin
        if (pop_fire && push_i) begin
          top_d = push_data_i;
        end else if (pop_fire) begin
          cnt_d = 2'd0;
        end else if (push_i) begin
          bot_d = push_data_i;
          cnt_d = 2'd2;
        end
      end
      default: begin
        if (pop_fire && push_i) begin
          top_d  = bot_q;
          bot_d  = push_data_i;
          lost_d = 1'b0;
        end else if (pop_fire) begin
          top_d  = bot_q;
          cnt_d  = 2'd1;
          lost_d = 1'b0;
        end else if (push_i) begin
          top_d  = bot_q;
          bot_d  = push_data_i;
          lost_d = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q  <= '0;
      bot_q  <= '0;
      cnt_q  <= 2'd0;
      lost_q <= 1'b0;
    end else begin
      top_q  <= top_d;
      bot_q  <= bot_d;
      cnt_q  <= cnt_d;
      lost_q <= lost_d;
    end
  end

  always_comb begin
    unique case (cnt_q)
      2'd0:    status_o = ST_EMPTY;
      2'd1:    status_o = ST_ONE;
      default: status_o = lost_q ? ST_LOST : ST_TWO;
    endcase
  end

  assign valid_o = (cnt_q != 2'd0);
  assign data_o  = top_q;

  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && !push_i) |=> ($stable(data_o) && status_o == ST_EMPTY)); // R9
  AST_LOSS_FROM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == ST_LOST) |-> ($past(status_o) == ST_TWO || $past(status_o) == ST_LOST)); // R7
  AST_POP_CLEARS_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == ST_LOST && ready_i && !push_i) |=> (status_o == ST_ONE)); // R8
  AST_PROMOTE: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == ST_TWO && ready_i && !push_i) |=> (data_o == $past(bot_q))); // R6
  AST_BOTH_FROM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == 2'd2 && ready_i && push_i) |=> (status_o == ST_TWO && data_o == $past(bot_q))); // R10
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import ecap_pkg::*;
#(
  parameter int unsigned W           = STAMP_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pin_i,
  input  logic         cap_en_i,
  input  logic [1:0]   edge_mode_i,
  input  logic         tbase_sel_i,
  input  logic [W-1:0] tmr_a_i,
  input  logic [W-1:0] tmr_b_i,
  output logic         pop_valid_o,
  input  logic         pop_ready_i,
  output logic [W-1:0] pop_data_o,
  output logic [1:0]   status_o,
  output logic         cap_evt_o
);
  logic         pin_sync;
  logic         hit;
  logic [W-1:0] stamp;

  ecap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pin_i),
    .sync_o  (pin_sync)
  );

  ecap_edge_detect u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (pin_sync),
    .en_i    (cap_en_i),
    .mode_i  (edge_mode_i),
    .hit_o   (hit)
  );

  assign stamp = tbase_sel_i ? tmr_b_i : tmr_a_i;

  ecap_stack #(.W(W)) u_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (hit),
    .push_data_i (stamp),
    .ready_i     (pop_ready_i),
    .valid_o     (pop_valid_o),
    .data_o      (pop_data_o),
    .status_o    (status_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_evt_o <= 1'b0;
    else        cap_evt_o <= hit;
  end

  AST_DISABLED_NO_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en_i |=> !cap_evt_o); // R3
  AST_VALID_MATCHES_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid_o == (status_o != ST_EMPTY)); // R5
  AST_EVT_PUSH_STAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !pop_valid_o) |=> (cap_evt_o && pop_data_o == $past(stamp))); // R4
endmodule

// File: tb/edge_capture_unit_test.sv
module edge_capture_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        sel = 1'b0;
  logic [15:0] ta = '0, tb_cnt = '0;
  logic        valid, ready = 1'b0, evt;
  logic [15:0] data;
  logic [1:0]  status;

  int checks = 0, fails = 0;
  logic [15:0] q[$];
  logic        lost = 1'b0;
  logic [15:0] last_top = '0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  edge_capture_unit uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .cap_en_i(en), .edge_mode_i(mode),
    .tbase_sel_i(sel), .tmr_a_i(ta), .tmr_b_i(tb_cnt), .pop_valid_o(valid),
    .pop_ready_i(ready), .pop_data_o(data), .status_o(status), .cap_evt_o(evt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_status();
    if (q.size() == 0) return 2'b00;
    if (q.size() == 1) return 2'b01;
    return lost ? 2'b11 : 2'b10;
  endfunction

  // scoreboard model: pop first, then push
  task automatic model_push(input logic [15:0] v);
    if (q.size() == 2) begin
      void'(q.pop_front());
      lost = 1'b1;
    end
    q.push_back(v);
    last_top = q[0];
  endtask

  task automatic model_pop();
    if (q.size() > 0) begin
      void'(q.pop_front());
      lost = 1'b0;
      if (q.size() > 0) last_top = q[0];
    end
  endtask

  task automatic check_state(input string req);
    chk({req, " status"}, status, exp_status());
    chk({req, " valid"}, valid, q.size() != 0);
    chk({req, " data"}, data, last_top);
  endtask

  // drive pin to v; cap says whether a capture is expected
  task automatic pin_to(input logic v, input logic cap, input logic [15:0] stamp, input string req);
    @(negedge clk); pin = v;
    @(negedge clk);
    @(negedge clk);
    chk({"R12 early evt ", req}, evt, 1'b0);
    check_state({"R12 early ", req});
    @(negedge clk);
    if (cap) model_push(stamp);
    chk({"R11 evt ", req}, evt, cap);
    check_state(req);
    @(negedge clk);
    chk({"R11 evt width ", req}, evt, 1'b0);
  endtask

  // monitor side of the scoreboard: one pop
  task automatic pop_one(input string req);
    @(negedge clk); ready = 1'b1;
    chk({req, " offered valid"}, valid, q.size() != 0);
    chk({req, " offered data"}, data, last_top);
    @(negedge clk); ready = 1'b0;
    model_pop();
    check_state(req);
  endtask

  // pin change whose capturing edge also carries a pop
  task automatic pin_with_pop(input logic v, input logic [15:0] stamp, input string req);
    @(negedge clk); pin = v;
    @(negedge clk);
    @(negedge clk); ready = 1'b1;
    chk({req, " offered data"}, data, last_top);
    @(negedge clk); ready = 1'b0;
    model_pop();
    model_push(stamp);
    chk({req, " evt"}, evt, 1'b1);
    check_state(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status", status, 2'b00);
    chk("R1 valid", valid, 1'b0);
    chk("R1 evt", evt, 1'b0);
    chk("R1 data", data, 16'h0);
    rst_n = 1'b1;
    en = 1'b1; mode = 2'b01; sel = 1'b0; ta = 16'h1A1A; tb_cnt = 16'hB0B0;
    pin_to(1'b1, 1'b1, 16'h1A1A, "R2 rise R4 tmrA R5 one");
    pin_to(1'b0, 1'b0, 16'h0, "R2 fall ignored in rise mode");
    mode = 2'b10; sel = 1'b1; tb_cnt = 16'hB222;
    pin_to(1'b1, 1'b0, 16'h0, "R2 rise ignored in fall mode");
    pin_to(1'b0, 1'b1, 16'hB222, "R2 fall R4 tmrB R5 two");
    mode = 2'b11; sel = 1'b0; ta = 16'h3333;
    pin_to(1'b1, 1'b1, 16'h3333, "R7 overflow R5 lost");
    ta = 16'h4444;
    pin_to(1'b0, 1'b1, 16'h4444, "R7 second overflow both mode");
    pop_one("R8 R6 pop from lost");
    pop_one("R6 pop last");
    pop_one("R9 pop empty");
    ready = 1'b1; repeat (3) @(negedge clk); ready = 1'b0;
    check_state("R9 ready held on empty");
    mode = 2'b00; ta = 16'h5555;
    pin_to(1'b1, 1'b0, 16'h0, "R2 none mode");
    pin_to(1'b0, 1'b0, 16'h0, "R2 none mode fall");
    mode = 2'b11; en = 1'b0;
    pin_to(1'b1, 1'b0, 16'h0, "R3 disabled");
    pin_to(1'b0, 1'b0, 16'h0, "R3 disabled fall");
    en = 1'b1; ta = 16'h6001;
    pin_to(1'b1, 1'b1, 16'h6001, "R10 setup one");
    ta = 16'h6002;
    pin_with_pop(1'b0, 16'h6002, "R10 pop+push from one");
    ta = 16'h6003;
    pin_to(1'b1, 1'b1, 16'h6003, "R10 setup two");
    ta = 16'h6004;
    pin_with_pop(1'b0, 16'h6004, "R10 pop+push from two");
    ta = 16'h6005;
    pin_to(1'b1, 1'b1, 16'h6005, "R10 setup lost");
    ta = 16'h6006;
    pin_with_pop(1'b0, 16'h6006, "R10 pop+push from lost");
    pop_one("R6 drain one");
    pop_one("R6 drain two");
    chk("R5 empty at end", status, 2'b00);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule